// File: doc/BRIEF.md
# Stack Pointer Register with Push/Pop Stepping

This block holds the 16-bit stack pointer of a small 8-bit processor core, together with the logic that moves it. Software reaches the pointer through the core's byte-wide register bus. The pointer appears there as two byte registers, one for the upper half and one for the lower half. Each byte has an address in the I/O space and a second address in the data-memory map, which is the I/O address plus 0x20. All 16 bits are significant.

The core's control logic asks for stack adjustments through a valid/ready request channel. Four request kinds exist: a one-byte data push or pop, and a two-byte return-address push or pop. The block turns each request into a stream of stack memory accesses, one per cycle. Each access carries the address to use and a write/read flag. A push writes at the current pointer and then moves it down by one. A pop moves the pointer up by one and reads at the new value. A two-byte request therefore becomes two consecutive accesses, and the pointer ends up moved by two.

Back-pressure rules: a request is taken in a cycle when `req_valid` and `req_ready` are both high. While the second access of a two-byte request is issued, `req_ready` is low and the request inputs are ignored. The memory side cannot stall: it must take an access in every cycle that `mem_valid` is high.

Top module: `sp_unit`

## Requirements
- R1: After reset the pointer reads 0x0000 and both byte registers read 0x00.
- R2: With `bus_space`=0 (I/O space), address 0x3E selects the upper byte and 0x3D selects the lower byte. A write replaces that byte only. `bus_rdata` returns the selected byte in the same cycle.
- R3: With `bus_space`=1 (data-memory map), the same bytes answer at 0x5E (upper) and 0x5D (lower). No other address in either space is decoded: `bus_hit` stays 0, `bus_rdata` is 0x00, and a write leaves the pointer unchanged.
- R4: `req_kind`=0 (one-byte push) produces one access with `mem_write`=1 at address SP. The pointer becomes SP-1.
- R5: `req_kind`=1 (one-byte pop) produces one access with `mem_write`=0 at address SP+1. The pointer becomes SP+1.
- R6: `req_kind`=2 (two-byte push) produces write accesses at SP and then SP-1 on two consecutive cycles. `req_ready` is low during the second cycle, and the pointer ends at SP-2.
- R7: `req_kind`=3 (two-byte pop) produces read accesses at SP+1 and then SP+2 on two consecutive cycles. `req_ready` is low during the second cycle, and the pointer ends at SP+2.
- R8: Pointer arithmetic wraps modulo 2^16 with no flag: a push at 0x0000 leaves 0xFFFF, and a pop at 0xFFFF leaves 0x0000.
- R9: When a decoded byte write and a memory access fall in the same cycle, the write wins. The written byte takes the bus data, the other byte keeps its value, and the pointer is not stepped in that cycle. The memory access is still issued at the address computed from the pointer before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_space | input | 1 | 0: I/O space address, 1: data-memory-map address |
| bus_addr | input | 8 | Register bus address |
| bus_we | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Selected pointer byte, 0 when not decoded |
| bus_hit | output | 1 | Address selects one of the two pointer bytes |
| req_valid | input | 1 | Adjust request present |
| req_kind | input | 2 | 0 push byte, 1 pop byte, 2 push address, 3 pop address |
| req_ready | output | 1 | Block can take a request this cycle |
| mem_valid | output | 1 | Stack memory access issued this cycle |
| mem_write | output | 1 | 1 for a push write, 0 for a pop read |
| mem_addr | output | 16 | Stack memory address of the access |
| sp_out | output | 16 | Current pointer value |

## Verification
The register bus write and the pointer step can land on the same clock edge. The bench provokes this by raising a push request and a low-byte write in one cycle. It then judges the result on two sides. The scoreboard must see the access at the old pointer address, and `sp_out` must show the new low byte beside an unchanged high byte, with no decrement applied. The wrap corners at 0x0000 and 0xFFFF, and a two-byte pop that crosses the wrap, are checked the same way through the access stream and the pointer value.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    K_PUSH1 = 2'd0,
    K_POP1  = 2'd1,
    K_PUSH2 = 2'd2,
    K_POP2  = 2'd3
  } sp_kind_e;
endpackage

// File: rtl/sp_decode.sv
module sp_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] IO_HI   = 8'h3E,
  parameter logic [ADDR_W-1:0] IO_LO   = 8'h3D,
  parameter logic [ADDR_W-1:0] MEM_OFS = 8'h20
) (
  input  logic              space,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_hi,
  output logic              sel_lo
);
  localparam logic [ADDR_W-1:0] MAP_HI = IO_HI + MEM_OFS;
  localparam logic [ADDR_W-1:0] MAP_LO = IO_LO + MEM_OFS;

  always_comb begin
    if (space) begin
      sel_hi = (addr == MAP_HI);
      sel_lo = (addr == MAP_LO);
    end else begin
      sel_hi = (addr == IO_HI);
      sel_lo = (addr == IO_LO);
    end
  end
endmodule

// File: rtl/sp_seq.sv
module sp_seq
  import sp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  sp_kind_e req_kind,
  output logic     req_ready,
  output logic     step,
  output logic     step_down
);
  logic busy_q, down_q;
  logic accept;

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign step      = accept || busy_q;
  // kinds with bit 0 clear are pushes
  assign step_down = busy_q ? down_q : !req_kind[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      down_q <= 1'b0;
    end else if (busy_q) begin
      busy_q <= 1'b0;
    end else if (accept && req_kind[1]) begin
      busy_q <= 1'b1;
      down_q <= !req_kind[0];
    end
  end
endmodule

// File: rtl/sp_reg.sv
module sp_reg #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_hi,
  input  logic                  wr_lo,
  input  logic [BYTE_W-1:0]     wdata,
  input  logic                  step,
  input  logic                  step_down,
  output logic [2*BYTE_W-1:0]   sp
);
  localparam int PTR_W = 2 * BYTE_W;
  logic [PTR_W-1:0] sp_q, sp_d;

  always_comb begin
    sp_d = sp_q;
    if (wr_hi)
      sp_d[PTR_W-1:BYTE_W] = wdata;
    else if (wr_lo)
      sp_d[BYTE_W-1:0] = wdata;
    else if (step)
      sp_d = step_down ? sp_q - PTR_W'(1) : sp_q + PTR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  assign sp = sp_q;
endmodule

// File: rtl/sp_unit.sv
module sp_unit
  import sp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] IO_HI   = 8'h3E,
  parameter logic [ADDR_W-1:0] IO_LO   = 8'h3D,
  parameter logic [ADDR_W-1:0] MEM_OFS = 8'h20,
  localparam int PTR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_space,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              bus_hit,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  output logic              req_ready,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [PTR_W-1:0]  sp_out
);
  logic sel_hi, sel_lo;
  logic step, step_down;
  logic [PTR_W-1:0] sp;

  sp_decode #(.ADDR_W(ADDR_W), .IO_HI(IO_HI), .IO_LO(IO_LO), .MEM_OFS(MEM_OFS)) u_dec (
    .space (bus_space),
    .addr  (bus_addr),
    .sel_hi(sel_hi),
    .sel_lo(sel_lo)
  );

  sp_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_kind (sp_kind_e'(req_kind)),
    .req_ready(req_ready),
    .step     (step),
    .step_down(step_down)
  );

  sp_reg #(.BYTE_W(BYTE_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hi    (bus_we && sel_hi),
    .wr_lo    (bus_we && sel_lo),
    .wdata    (bus_wdata),
    .step     (step),
    .step_down(step_down),
    .sp       (sp)
  );

  // push: write at current pointer; pop: read one above it
  assign mem_valid = step;
  assign mem_write = step_down;
  assign mem_addr  = step_down ? sp : sp + PTR_W'(1);
  assign sp_out    = sp;
  assign bus_hit   = sel_hi || sel_lo;
  assign bus_rdata = sel_hi ? sp[PTR_W-1:BYTE_W] : (sel_lo ? sp[BYTE_W-1:0] : '0);
endmodule

// File: rtl/sp_unit_chk.sv
module sp_unit_chk #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 8,
  localparam int PTR_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_space,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              bus_hit,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_write,
  input logic [PTR_W-1:0]  mem_addr,
  input logic [PTR_W-1:0]  sp_out
);
  logic hi_w, wr_any;
  assign hi_w   = bus_we && bus_hit && (bus_addr == (bus_space ? 8'h5E : 8'h3E));
  assign wr_any = bus_we && bus_hit;

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> sp_out == '0);

  p_rdata_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hit |-> bus_rdata == '0);

  p_miss_no_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_hit && !mem_valid) |=> $stable(sp_out));

  p_push_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && !wr_any) |=> sp_out == $past(mem_addr) - PTR_W'(1));

  p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_write && !wr_any) |=> sp_out == $past(mem_addr));

  p_second_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind[1]) |=>
      (mem_valid && !req_ready && mem_write == !$past(req_kind[0])));

  p_io_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hi_w |=> (sp_out[PTR_W-1:BYTE_W] == $past(bus_wdata)) &&
             (sp_out[BYTE_W-1:0] == $past(sp_out[BYTE_W-1:0])));
endmodule

bind sp_unit sp_unit_chk u_chk (.*);

// File: tb/tb_sp_unit.sv
module tb_sp_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_space = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_we = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic        bus_hit;
  logic        req_valid = 0;
  logic [1:0]  req_kind = 0;
  logic        req_ready;
  logic        mem_valid, mem_write;
  logic [15:0] mem_addr, sp_out;

  int checks = 0, errors = 0;
  logic [16:0] exp_q[$];   // {write, addr}
  logic [15:0] model_sp;

  always #10 clk = ~clk;

  sp_unit dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expected accesses as the design issues them
  always @(negedge clk) begin
    if (rst_n && mem_valid) begin
      if (exp_q.size() == 0) chk("access_stream unexpected", {mem_write, mem_addr}, 17'h0);
      else chk("access_stream R4-R7 order", {15'd0, mem_write, mem_addr}, {15'd0, exp_q.pop_front()});
    end
  end

  task automatic bus_wr(logic sp_, logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    bus_space = sp_; bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic bus_rd(string tag, logic sp_, logic [7:0] a, logic [7:0] exp, logic exp_hit);
    @(posedge clk); #1;
    bus_space = sp_; bus_addr = a;
    @(negedge clk);
    chk(tag, {bus_hit, bus_rdata}, {exp_hit, exp});
  endtask

  // driver: queue expected accesses, update model, issue request
  task automatic do_op(logic [1:0] k, string tag);
    int n = k[1] ? 2 : 1;
    for (int i = 0; i < n; i++) begin
      if (!k[0]) begin exp_q.push_back({1'b1, model_sp}); model_sp = model_sp - 16'd1; end
      else begin model_sp = model_sp + 16'd1; exp_q.push_back({1'b0, model_sp}); end
    end
    @(posedge clk); #1;
    req_kind = k; req_valid = 1;
    @(posedge clk); #1;
    req_valid = 0;
    if (n == 2) begin
      chk({tag, " ready low in second cycle"}, req_ready, 0);
      @(posedge clk); #1;
    end
    chk({tag, " pointer"}, sp_out, model_sp);
    chk({tag, " queue drained"}, exp_q.size(), 0);
  endtask

  task automatic set_sp(logic [15:0] v);
    bus_wr(0, 8'h3E, v[15:8]);
    bus_wr(0, 8'h3D, v[7:0]);
    model_sp = v;
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_sp = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset pointer", sp_out, 16'h0000);
    chk("R1 reset ready", req_ready, 1);
    bus_rd("R1 reset high byte", 0, 8'h3E, 8'h00, 1);
    bus_rd("R1 reset low byte", 0, 8'h3D, 8'h00, 1);

    bus_wr(0, 8'h3E, 8'h12);
    bus_wr(0, 8'h3D, 8'h34);
    chk("R2 io writes", sp_out, 16'h1234);
    bus_rd("R2 io read high", 0, 8'h3E, 8'h12, 1);
    bus_rd("R2 io read low", 0, 8'h3D, 8'h34, 1);

    bus_wr(1, 8'h5E, 8'hAB);
    chk("R3 map write high only", sp_out, 16'hAB34);
    bus_wr(1, 8'h5D, 8'hCD);
    chk("R3 map write low", sp_out, 16'hABCD);
    bus_rd("R3 map read high", 1, 8'h5E, 8'hAB, 1);
    bus_rd("R3 map read low", 1, 8'h5D, 8'hCD, 1);
    bus_wr(1, 8'h3E, 8'h00);
    bus_wr(0, 8'h5D, 8'h00);
    bus_wr(0, 8'h3F, 8'h00);
    chk("R3 undecoded writes ignored", sp_out, 16'hABCD);
    bus_rd("R3 io addr in map space", 1, 8'h3E, 8'h00, 0);
    bus_rd("R3 map addr in io space", 0, 8'h5E, 8'h00, 0);
    model_sp = 16'hABCD;

    do_op(2'd0, "R4 push byte");
    do_op(2'd1, "R5 pop byte");
    do_op(2'd2, "R6 push address");
    do_op(2'd3, "R7 pop address");
    chk("R7 back to start", sp_out, 16'hABCD);

    set_sp(16'h0000);
    do_op(2'd0, "R8 push at zero");
    chk("R8 wrap down", sp_out, 16'hFFFF);
    do_op(2'd1, "R8 pop at top");
    chk("R8 wrap up", sp_out, 16'h0000);
    set_sp(16'hFFFF);
    do_op(2'd3, "R8 pop address across wrap");
    chk("R8 wrap by two", sp_out, 16'h0001);

    // R9: push and low-byte write in the same cycle
    set_sp(16'h1000);
    exp_q.push_back({1'b1, 16'h1000});
    @(posedge clk); #1;
    req_kind = 2'd0; req_valid = 1;
    bus_space = 0; bus_addr = 8'h3D; bus_wdata = 8'h55; bus_we = 1;
    @(posedge clk); #1;
    req_valid = 0; bus_we = 0;
    chk("R9 write wins over step", sp_out, 16'h1055);
    chk("R9 access still issued", exp_q.size(), 0);

    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule